// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block takes a multi-output clock generator into a low-power state and brings it back. An asynchronous, active-low request `pd_req_n` asks for power-down. The block first parks every output clock low, then turns off the VCO and then the crystal. On release it turns the crystal on first and then the VCO. It waits a programmable settling time counted on an always-on slow clock, and then lets the outputs run again. Outputs are enabled and disabled only while their source clock is low, so no output ever shows a shortened high pulse.

Two outputs are fast and derived from the VCO clock: a processor clock and a bus clock. Each has its own active-high stop request, synchronous to `fast_clk`. Two outputs are slow: one from a VCO-derived 48 MHz clock and one from the crystal reference. The slow outputs have no stop request. They park through a synchronizer in their own domain, so parking can take a few of their own cycles. The sequencer runs on `aon_clk`, which never stops. The oscillators, the PLL and the dividers are outside the block and are seen only as enables and input clocks.

Top module: `clk_pd_seq`

## Requirements
- R1: `pd_req_n` passes through a two-flop synchronizer on `fast_clk`. Both fast outputs stop low at a falling edge of `fast_clk`, no later than three `fast_clk` periods after `pd_req_n` falls.
- R2: `vco_en` falls only when all four outputs are parked low. `xtal_en` falls exactly one `aon_clk` cycle after `vco_en` falls.
- R3: The sequencer visits its eight states only in this cyclic order: run, gate fast, gate slow, oscillators off, down, oscillators on, settle, ungate, and back to run.
- R4: While running, `cpu_stop`=1 parks `cpu_out` low and `pci_stop`=1 parks `pci_out` low, each at the next falling edge of `fast_clk`. Each request affects only its own output.
- R5: From the gate-slow state until the outputs are released again, the stop requests have no effect and the fast outputs stay low. After release, each fast output follows the level its stop request has at that time.
- R6: The slow outputs `usb_out` and `ref_out` park low within three `aon_clk` cycles plus three of their own clock periods after `pd_req_n` falls.
- R7: On exit, `xtal_en` rises at the third `aon_clk` rising edge after `pd_req_n` rises in the down state. `vco_en` rises one cycle later. The outputs stay low until the (SETTLE_CYC+4)-th edge and run within three `fast_clk` periods after it. The default SETTLE_CYC of 80 keeps this exit latency under 3 ms with a 32.768 kHz `aon_clk`.
- R8: If `pd_req_n` returns high partway through entry, the entry still completes (both oscillator enables go low once) and the full exit sequence follows without further stimulus.
- R9: After reset the sequencer is running, `vco_en` and `xtal_en` are 1 and all four outputs toggle.
- R10: Every high pulse on every output lasts the full high time of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk | input | 1 | Free-running slow clock for the sequencer and settle counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_clk | input | 1 | VCO-derived fast source clock |
| usb_clk | input | 1 | VCO-derived 48 MHz source clock |
| ref_clk | input | 1 | Crystal reference source clock |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop | input | 1 | Stop request for `cpu_out`, active high, synchronous to `fast_clk` |
| pci_stop | input | 1 | Stop request for `pci_out`, active high, synchronous to `fast_clk` |
| cpu_out | output | 1 | Gated processor clock |
| pci_out | output | 1 | Gated bus clock |
| usb_out | output | 1 | Gated 48 MHz clock |
| ref_out | output | 1 | Gated reference clock |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
On every cycle, the assertions check the legal state order, the parking of all outputs before the VCO turns off, the one-cycle gap between the two oscillator enables, and the crystal-first order on exit. They also check that the enables stay quiet during the sequence and that each synchronized request is followed by a dropped enable. Other behaviour needs the bench's timed scenarios. These cover the end-to-end latency bounds measured from the asynchronous request, the full width of every output pulse, and the exact settle window. They also cover the completion of an entry that was cancelled partway and the output levels after release under random stop patterns.

// File: rtl/clk_pd_seq.sv
`timescale 1ns/1ps
module clk_pd_seq #(
  parameter int SETTLE_CYC = 80
) (
  input  logic aon_clk,
  input  logic rst_n,
  input  logic fast_clk,
  input  logic usb_clk,
  input  logic ref_clk,
  input  logic pd_req_n,
  input  logic cpu_stop,
  input  logic pci_stop,
  output logic cpu_out,
  output logic pci_out,
  output logic usb_out,
  output logic ref_out,
  output logic vco_en,
  output logic xtal_en
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  typedef enum logic [2:0] {
    S_RUN, S_GFAST, S_GSLOW, S_OSCOFF, S_DOWN, S_OSCON, S_SETTLE, S_UNGATE
  } st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic permit;
  logic pd_a1, pd_a2;
  logic fi_a1, fi_a2;
  logic [1:0] si_a1, si_a2;
  logic [1:0] slow_en, slow_idle;
  wire  [1:0] sclk = {ref_clk, usb_clk};

  // sequencer on the always-on clock
  always_ff @(posedge aon_clk or negedge rst_n)
    if (!rst_n) begin
      pd_a1 <= 1'b1; pd_a2 <= 1'b1;
      fi_a1 <= 1'b0; fi_a2 <= 1'b0;
      si_a1 <= '0;   si_a2 <= '0;
    end else begin
      pd_a1 <= pd_req_n; pd_a2 <= pd_a1;
      fi_a1 <= fast_idle; fi_a2 <= fi_a1;
      si_a1 <= slow_idle; si_a2 <= si_a1;
    end

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:    if (!pd_a2) st_nx = S_GFAST;
      S_GFAST:  if (fi_a2) st_nx = S_GSLOW;
      S_GSLOW:  if (&si_a2) st_nx = S_OSCOFF;
      S_OSCOFF: st_nx = S_DOWN;
      S_DOWN:   if (pd_a2) st_nx = S_OSCON;
      S_OSCON:  st_nx = S_SETTLE;
      S_SETTLE: if (cnt == LAST) st_nx = S_UNGATE;
      S_UNGATE: if (!fi_a2 && si_a2 == 2'b00) st_nx = S_RUN;
      default:  st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge aon_clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_RUN; cnt <= '0;
      permit <= 1'b1; vco_en <= 1'b1; xtal_en <= 1'b1;
    end else begin
      st      <= st_nx;
      cnt     <= (st == S_SETTLE && st_nx == S_SETTLE) ? cnt + 1'b1 : '0;
      permit  <= (st_nx == S_RUN) || (st_nx == S_UNGATE);
      vco_en  <= !(st_nx inside {S_OSCOFF, S_DOWN, S_OSCON});
      xtal_en <= (st_nx != S_DOWN);
    end

  // fast domain: request and permission synchronizers, falling-edge enables
  logic pd_c1, pd_c2, pm_c1, pm_c2, cpu_en, pci_en, fast_idle;

  always_ff @(posedge fast_clk or negedge rst_n)
    if (!rst_n) begin
      pd_c1 <= 1'b1; pd_c2 <= 1'b1;
      pm_c1 <= 1'b1; pm_c2 <= 1'b1;
      fast_idle <= 1'b0;
    end else begin
      pd_c1 <= pd_req_n; pd_c2 <= pd_c1;
      pm_c1 <= permit;   pm_c2 <= pm_c1;
      fast_idle <= !pm_c2 && !cpu_en && !pci_en;
    end

  always_ff @(negedge fast_clk or negedge rst_n)
    if (!rst_n) begin
      cpu_en <= 1'b0; pci_en <= 1'b0;
    end else begin
      cpu_en <= pd_c2 && pm_c2 && !cpu_stop;
      pci_en <= pd_c2 && pm_c2 && !pci_stop;
    end

  assign cpu_out = fast_clk & cpu_en;
  assign pci_out = fast_clk & pci_en;

  // slow domains: index 0 = 48 MHz, index 1 = reference
  for (genvar g = 0; g < 2; g++) begin : g_slow
    logic p1, p2, en, idle;
    always_ff @(posedge sclk[g] or negedge rst_n)
      if (!rst_n) begin
        p1 <= 1'b1; p2 <= 1'b1; idle <= 1'b0;
      end else begin
        p1 <= permit; p2 <= p1;
        idle <= !p2 && !en;
      end
    always_ff @(negedge sclk[g] or negedge rst_n)
      if (!rst_n) en <= 1'b0;
      else        en <= p2;
    assign slow_en[g]   = en;
    assign slow_idle[g] = idle;

    a_r6_slow_park: assert property (@(negedge sclk[g]) disable iff (!rst_n)
      !p2 |=> !en);
  end

  assign usb_out = usb_clk & slow_en[0];
  assign ref_out = ref_clk & slow_en[1];

  a_r1_fast_stop: assert property (@(negedge fast_clk) disable iff (!rst_n)
    !pd_c2 |=> (!cpu_en && !pci_en));

  a_r4_cpu_stop: assert property (@(negedge fast_clk) disable iff (!rst_n)
    cpu_stop |=> !cpu_en);

  a_r4_pci_stop: assert property (@(negedge fast_clk) disable iff (!rst_n)
    pci_stop |=> !pci_en);

  a_r2_parked_before_vco_off: assert property (@(posedge aon_clk) disable iff (!rst_n)
    $fell(vco_en) |-> (!cpu_en && !pci_en && slow_en == 2'b00));

  a_r2_xtal_follows_vco: assert property (@(posedge aon_clk) disable iff (!rst_n)
    $fell(vco_en) |=> $fell(xtal_en));

  a_r3_state_order: assert property (@(posedge aon_clk) disable iff (!rst_n)
    (st != $past(st)) |-> (st == st_t'(3'($past(st)) + 3'd1)));

  a_r5_fast_quiet: assert property (@(posedge aon_clk) disable iff (!rst_n)
    (st inside {S_GSLOW, S_OSCOFF, S_DOWN, S_OSCON, S_SETTLE}) |-> (!cpu_en && !pci_en));

  a_r5_slow_quiet: assert property (@(posedge aon_clk) disable iff (!rst_n)
    (st inside {S_OSCOFF, S_DOWN, S_OSCON, S_SETTLE}) |-> (slow_en == 2'b00));

  a_r7_xtal_first: assert property (@(posedge aon_clk) disable iff (!rst_n)
    $rose(vco_en) |-> (xtal_en && $past(xtal_en)));

  a_r7_settle_hold: assert property (@(posedge aon_clk) disable iff (!rst_n)
    (st == S_SETTLE && cnt != LAST) |=> (st == S_SETTLE && !permit));
endmodule

// File: tb/test_clk_pd_seq.sv
`timescale 1ns/1ps
module test_clk_pd_seq;
  localparam int S = 12;
  localparam real FH = 3.6, UH = 10.4, RH = 35.0;

  logic aon_clk = 1'b0, rst_n = 1'b0;
  logic fast_clk = 1'b0, usb_clk = 1'b0, ref_clk = 1'b0;
  logic pd_req_n = 1'b1, cpu_stop = 1'b0, pci_stop = 1'b0;
  logic cpu_out, pci_out, usb_out, ref_out, vco_en, xtal_en;

  int n_chk = 0, n_bad = 0, glitches = 0;
  int c_cpu = 0, c_pci = 0, c_usb = 0, c_ref = 0, n_vfall = 0;
  real r_cpu = 0, r_pci = 0, r_usb = 0, r_ref = 0, t_pd = 0, t_vfall = 0;

  clk_pd_seq #(.SETTLE_CYC(S)) i_clk_pd_seq (
    .aon_clk(aon_clk), .rst_n(rst_n), .fast_clk(fast_clk), .usb_clk(usb_clk),
    .ref_clk(ref_clk), .pd_req_n(pd_req_n), .cpu_stop(cpu_stop), .pci_stop(pci_stop),
    .cpu_out(cpu_out), .pci_out(pci_out), .usb_out(usb_out), .ref_out(ref_out),
    .vco_en(vco_en), .xtal_en(xtal_en));

  always #10 aon_clk = ~aon_clk;
  always begin wait (vco_en === 1'b1);  #(FH) fast_clk = 1'b1; #(FH) fast_clk = 1'b0; end
  always begin wait (vco_en === 1'b1);  #(UH) usb_clk  = 1'b1; #(UH) usb_clk  = 1'b0; end
  always begin wait (xtal_en === 1'b1); #(RH) ref_clk  = 1'b1; #(RH) ref_clk  = 1'b0; end

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  function automatic bit exp_run(input bit stop); return !stop; endfunction
  function automatic int exit_edges(input int s); return s + 4; endfunction

  // pulse counting, width (R10) and entry-order monitors (R1, R2, R6)
  always @(posedge cpu_out) begin c_cpu++; r_cpu = $realtime; end
  always @(posedge pci_out) begin c_pci++; r_pci = $realtime; end
  always @(posedge usb_out) begin c_usb++; r_usb = $realtime; end
  always @(posedge ref_out) begin c_ref++; r_ref = $realtime; end
  always @(negedge cpu_out) if (rst_n && $realtime - r_cpu < FH - 0.01) glitches++;
  always @(negedge pci_out) if (rst_n && $realtime - r_pci < FH - 0.01) glitches++;
  always @(negedge usb_out) if (rst_n && $realtime - r_usb < UH - 0.01) glitches++;
  always @(negedge ref_out) if (rst_n && $realtime - r_ref < RH - 0.01) glitches++;

  always @(negedge vco_en) if (rst_n) begin
    n_vfall++;
    t_vfall = $realtime;
    chk({cpu_out, pci_out, usb_out, ref_out} == 4'b0, "R2", "outputs at vco off", real'({cpu_out, pci_out, usb_out, ref_out}), 0);
    chk(r_cpu <= t_pd + 3 * 2 * FH && r_pci <= t_pd + 3 * 2 * FH, "R1", "last fast rise after request",
        (r_cpu > r_pci ? r_cpu : r_pci) - t_pd, 3 * 2 * FH);
    chk(r_usb <= t_pd + 60 + 3 * 2 * UH, "R6", "last usb rise after request", r_usb - t_pd, 60 + 3 * 2 * UH);
    chk(r_ref <= t_pd + 60 + 3 * 2 * RH, "R6", "last ref rise after request", r_ref - t_pd, 60 + 3 * 2 * RH);
  end
  always @(negedge xtal_en) if (rst_n)
    chk($realtime - t_vfall > 19.9 && $realtime - t_vfall < 20.1, "R2", "xtal off delay ns", $realtime - t_vfall, 20);

  task automatic step(input int n);
    repeat (n) @(posedge aon_clk);
    #5.5;
  endtask

  task automatic drop_pd();
    pd_req_n = 1'b0;
    t_pd = $realtime;
  endtask

  task automatic activity(input string req, input bit e_cpu, input bit e_pci);
    int c0, p0;
    c0 = c_cpu; p0 = c_pci;
    step(3);
    chk((c_cpu != c0) == e_cpu, req, "cpu_out running", real'(c_cpu != c0), real'(e_cpu));
    chk((c_pci != p0) == e_pci, req, "pci_out running", real'(c_pci != p0), real'(e_pci));
  endtask

  task automatic wait_down(input string req);
    for (int k = 0; k < 400; k++) begin
      if (!xtal_en) break;
      step(1);
    end
    chk(!xtal_en && !vco_en, req, "reached down", real'({vco_en, xtal_en}), 0);
  endtask

  task automatic wait_up(input string req);
    for (int k = 0; k < 400; k++) begin
      if (vco_en && xtal_en) break;
      step(1);
    end
    chk(vco_en && xtal_en, req, "oscillators back", real'({vco_en, xtal_en}), 3);
    step(S + 8);
  endtask

  initial begin
    int c0, v0, w;
    void'($urandom(32'd4711));
    step(3);
    chk(vco_en && xtal_en && !cpu_out && !ref_out, "R9", "enables in reset", real'({vco_en, xtal_en}), 3);
    rst_n = 1'b1;
    step(3);
    c0 = c_usb; v0 = c_ref;
    activity("R9", 1'b1, 1'b1);
    step(3);
    chk(c_usb != c0 && c_ref != v0, "R9", "slow outputs running", real'(c_ref - v0), 1);

    // R4 directed stops
    cpu_stop = 1'b1; step(1);
    activity("R4", exp_run(1'b1), exp_run(1'b0));
    cpu_stop = 1'b0; pci_stop = 1'b1; step(1);
    activity("R4", exp_run(1'b0), exp_run(1'b1));
    pci_stop = 1'b0; step(1);

    // full entry, stop requests toggled while down (R5), exact exit timing (R7)
    drop_pd();
    step(2);
    c0 = c_cpu; step(1);
    chk(c_cpu == c0, "R1", "cpu_out stopped after request", real'(c_cpu - c0), 0);
    wait_down("R2");
    step(2);
    c0 = c_cpu; v0 = c_pci;
    cpu_stop = 1'b1; step(2); pci_stop = 1'b1; step(2); cpu_stop = 1'b0; step(2);
    chk(c_cpu == c0 && c_pci == v0, "R5", "fast pulses while down", real'(c_cpu - c0 + c_pci - v0), 0);
    pd_req_n = 1'b1;
    step(2);
    chk(!xtal_en, "R7", "xtal still off after two edges", real'(xtal_en), 0);
    step(1);
    chk(xtal_en && !vco_en, "R7", "xtal on first", real'({vco_en, xtal_en}), 1);
    step(1);
    chk(vco_en, "R7", "vco on next cycle", real'(vco_en), 1);
    c0 = c_cpu; v0 = c_pci;
    step(exit_edges(S) - 5);
    chk(c_cpu == c0 && c_pci == v0, "R7", "outputs held during settle", real'(c_cpu - c0 + c_pci - v0), 0);
    step(3);
    chk(c_cpu != c0, "R7", "cpu_out resumed", real'(c_cpu - c0), 1);
    chk(c_pci == v0, "R5", "pci_out follows held stop", real'(c_pci - v0), 0);
    pci_stop = 1'b0; step(S + 8);

    // R8 request withdrawn partway through entry
    v0 = n_vfall;
    drop_pd(); step(3); pd_req_n = 1'b1;
    wait_down("R8");
    wait_up("R8");
    chk(n_vfall == v0 + 1, "R8", "vco off events", real'(n_vfall - v0), 1);
    activity("R8", 1'b1, 1'b1);

    // random episodes
    for (int e = 0; e < 8; e++) begin
      bit sc, sp;
      sc = 1'($urandom % 2); sp = 1'($urandom % 2);
      cpu_stop = sc; pci_stop = sp; step(1);
      activity("R4", exp_run(sc), exp_run(sp));
      v0 = n_vfall;
      w = 3 + int'($urandom % 40);
      drop_pd(); step(w); pd_req_n = 1'b1;
      if (xtal_en) wait_down("R8");
      wait_up("R3");
      chk(n_vfall == v0 + 1, "R3", "one full cycle", real'(n_vfall - v0), 1);
      activity("R5", exp_run(sc), exp_run(sp));
    end

    chk(glitches == 0, "R10", "short high pulses", real'(glitches), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge aon_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule